// File: doc/BRIEF.md
# Residue-Mapped Memory Bank Mapper

This block takes word requests from a single valid/ready port and spreads them over a small set of single-ported banks. The bank is picked by residue arithmetic: the address modulo a prime bank count. In the default mode, the row inside the bank is the address modulo the power-of-two words-per-bank count. The two counts share no factor, so every address in the covered range has its own (bank, row) pair. Because the bank count is odd, accesses with a power-of-two stride still land on different banks.

A mode input switches to a plain sequential layout. In that layout the bank is still the address modulo the bank count, but the row is the quotient. Each bank stays busy for a parameterised number of cycles after an access, and a request that targets a busy bank stalls. A request to a free bank can be accepted in the same cycle. Addresses beyond the covered range are consumed without any bank access and raise a one-cycle error pulse. The banks are small behavioural arrays inside the block, so stored data can be read back through the port.

The default build uses 3 banks, 8 words per bank, 32-bit data, 8-bit addresses and a 6-cycle bank occupancy.

Top module: `imap_top`

## Requirements
- R1: `bank_o` always equals `req_addr_i` modulo NB, where NB = 2^BANK_BITS − 1 (default 3). This holds in both modes.
- R2: With `mode_i` = 0 (residue layout), `row_o` equals `req_addr_i` modulo WB, where WB = 2^ROW_BITS (default 8).
- R3: In the residue layout, every address from 0 to NB·WB − 1 maps to a distinct (bank, row) pair. With the defaults, address 9 maps to bank 0 row 0b001, and address 8 maps to bank 2 row 0.
- R4: With `mode_i` = 1 (sequential layout), `row_o` equals `req_addr_i` / NB, and data written in this layout reads back in the same layout.
- R5: A read (`req_we_i` = 0) accepted on a clock edge raises `rsp_valid_o` for exactly the following cycle. In that cycle, `rsp_rdata_o` carries the word last written to that address in the same layout.
- R6: After a bank is accessed, `req_ready_o` stays low and `busy_o` stays high for LAT − 1 cycles (default 5) for requests to that bank. A request to another bank is accepted during those cycles.
- R7: A request with `req_addr_i` ≥ NB·WB is accepted at once (`req_ready_o` = 1). It writes no bank and occupies no bank. On the next cycle `err_o` is 1 and `rsp_valid_o` is 0.
- R8: After reset, `rsp_valid_o` and `err_o` are 0, and every bank is free (`req_ready_o` = 1 and `busy_o` = 0 for an in-range address).
- R9: An accepted write (`req_we_i` = 1) produces no response: `rsp_valid_o` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| mode_i | input | 1 | 0 selects the residue layout, 1 selects the sequential layout |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be taken this cycle |
| req_addr_i | input | ADDR_W | Word address |
| req_we_i | input | 1 | 1 for a write, 0 for a read |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | DATA_W | Read data |
| err_o | output | 1 | Pulse marking an out-of-range request taken on the previous edge |
| bank_o | output | BANK_BITS | Bank picked for the present address |
| row_o | output | ROW_BITS | Row picked for the present address |
| busy_o | output | 1 | The addressed bank is still occupied |

## Verification
A wrong residue fold shows up on `bank_o` in the same cycle the address is driven. Read-back data also exposes a fold that is wrong for only a few addresses, because two addresses then share one cell and the later write wins. A bank counter that is loaded with the wrong value or fails to count down changes the number of stalled cycles seen on `req_ready_o`; the error is visible within LAT cycles of the access. A range check placed on the wrong side of the limit shows on the next cycle as a missing `err_o` pulse or as a corrupted word at the aliased location.

// File: rtl/imap_pkg.sv
package imap_pkg;
    typedef enum logic {
        MAP_RESIDUE    = 1'b0,
        MAP_SEQUENTIAL = 1'b1
    } map_mode_e;
endpackage

// File: rtl/imap_fold.sv
// Residue modulo (2^K - 1) by summing K-bit chunks with end-around carry.
module imap_fold #(
    parameter int ADDR_W = 8,
    parameter int K      = 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [K-1:0]      res_o
);
    localparam int NCH = (ADDR_W + K - 1) / K;

    logic [NCH*K-1:0] padded;
    logic [K-1:0]     acc [NCH+1];

    assign padded = (NCH*K)'(addr_i);
    assign acc[0] = '0;

    for (genvar i = 0; i < NCH; i++) begin : g_chunk
        logic [K:0] sum_w;
        assign sum_w    = {1'b0, acc[i]} + {1'b0, padded[i*K +: K]};
        assign acc[i+1] = sum_w[K-1:0] + {{(K-1){1'b0}}, sum_w[K]};
    end

    // all-ones is congruent to zero
    assign res_o = (&acc[NCH]) ? '0 : acc[NCH];
endmodule

// File: rtl/imap_locate.sv
module imap_locate
    import imap_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BANK_BITS = 2,
    parameter int ROW_BITS  = 3
) (
    input  logic [ADDR_W-1:0]    addr_i,
    input  map_mode_e            mode_i,
    output logic [BANK_BITS-1:0] bank_o,
    output logic [ROW_BITS-1:0]  row_o,
    output logic                 in_range_o
);
    localparam int NB    = (1 << BANK_BITS) - 1;
    localparam int WB    = 1 << ROW_BITS;
    localparam int LIMIT = NB * WB;

    logic [ROW_BITS-1:0] quot;

    imap_fold #(.ADDR_W(ADDR_W), .K(BANK_BITS)) u_fold (
        .addr_i (addr_i),
        .res_o  (bank_o)
    );

    always_comb begin
        quot       = ROW_BITS'(addr_i / ADDR_W'(NB));
        row_o      = (mode_i == MAP_SEQUENTIAL) ? quot : addr_i[ROW_BITS-1:0];
        in_range_o = {1'b0, addr_i} < (ADDR_W+1)'(LIMIT);
    end
endmodule

// File: rtl/imap_bank.sv
module imap_bank #(
    parameter int DATA_W   = 32,
    parameter int ROW_BITS = 3,
    parameter int LAT      = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                issue_i,
    input  logic                we_i,
    input  logic [ROW_BITS-1:0] row_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic                free_o,
    output logic [DATA_W-1:0]   rdata_o
);
    localparam int WB    = 1 << ROW_BITS;
    localparam int CNT_W = $clog2(LAT + 1);

    logic [DATA_W-1:0] mem_q [WB];
    logic [CNT_W-1:0]  cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (issue_i)
            cnt_d = CNT_W'(LAT - 1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    always_ff @(posedge clk) begin
        if (issue_i && we_i) mem_q[row_i] <= wdata_i;
    end

    assign free_o  = (cnt_q == '0);
    assign rdata_o = mem_q[row_i];
endmodule

// File: rtl/imap_top.sv
module imap_top
    import imap_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int BANK_BITS = 2,
    parameter int ROW_BITS  = 3,
    parameter int LAT       = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_i,
    input  logic                 req_valid_i,
    output logic                 req_ready_o,
    input  logic [ADDR_W-1:0]    req_addr_i,
    input  logic                 req_we_i,
    input  logic [DATA_W-1:0]    req_wdata_i,
    output logic                 rsp_valid_o,
    output logic [DATA_W-1:0]    rsp_rdata_o,
    output logic                 err_o,
    output logic [BANK_BITS-1:0] bank_o,
    output logic [ROW_BITS-1:0]  row_o,
    output logic                 busy_o
);
    localparam int NB = (1 << BANK_BITS) - 1;

    typedef struct packed {
        logic              rsp_valid;
        logic [DATA_W-1:0] rdata;
        logic              err;
    } state_t;

    state_t            st_d, st_q;
    logic              in_range, sel_free, accept, issue;
    logic [NB-1:0]     bank_free, bank_issue;
    logic [DATA_W-1:0] bank_rdata [NB];

    imap_locate #(.ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS), .ROW_BITS(ROW_BITS)) u_loc (
        .addr_i     (req_addr_i),
        .mode_i     (map_mode_e'(mode_i)),
        .bank_o     (bank_o),
        .row_o      (row_o),
        .in_range_o (in_range)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        assign bank_issue[b] = issue && (bank_o == BANK_BITS'(b));
        imap_bank #(.DATA_W(DATA_W), .ROW_BITS(ROW_BITS), .LAT(LAT)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .issue_i (bank_issue[b]),
            .we_i    (req_we_i),
            .row_i   (row_o),
            .wdata_i (req_wdata_i),
            .free_o  (bank_free[b]),
            .rdata_o (bank_rdata[b])
        );
    end

    always_comb begin
        sel_free    = bank_free[bank_o];
        busy_o      = in_range && !sel_free;
        req_ready_o = !in_range || sel_free;
        accept      = req_valid_i && req_ready_o;
        issue       = accept && in_range;

        st_d           = st_q;
        st_d.rsp_valid = issue && !req_we_i;
        st_d.err       = accept && !in_range;
        if (st_d.rsp_valid)
            st_d.rdata = bank_rdata[bank_o];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid_o = st_q.rsp_valid;
    assign rsp_rdata_o = st_q.rdata;
    assign err_o       = st_q.err;
endmodule

// File: rtl/imap_checker.sv
module imap_checker #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int BANK_BITS = 2,
    parameter int ROW_BITS  = 3,
    parameter int LAT       = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 mode_i,
    input logic                 req_valid_i,
    input logic                 req_ready_o,
    input logic [ADDR_W-1:0]    req_addr_i,
    input logic                 req_we_i,
    input logic                 rsp_valid_o,
    input logic                 err_o,
    input logic [BANK_BITS-1:0] bank_o,
    input logic [ROW_BITS-1:0]  row_o,
    input logic                 busy_o
);
    localparam int NB    = (1 << BANK_BITS) - 1;
    localparam int WB    = 1 << ROW_BITS;
    localparam int LIMIT = NB * WB;

    logic in_rng, acc;
    assign in_rng = int'(req_addr_i) < LIMIT;
    assign acc    = req_valid_i && req_ready_o;

    // R1 bank residue
    a_r1_bank_mod: assert property (@(posedge clk) disable iff (!rst_n)
        int'(bank_o) == int'(req_addr_i) % NB);

    // R2 row residue
    a_r2_row_mod: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i) |-> int'(row_o) == int'(req_addr_i) % WB);

    // R4 row quotient
    a_r4_row_quot: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && in_rng) |-> int'(row_o) == int'(req_addr_i) / NB);

    // R5 read response one cycle later
    a_r5_read_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_rng && !req_we_i) |=> rsp_valid_o);

    // R7 out-of-range pulse
    a_r7_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !in_rng) |=> (err_o && !rsp_valid_o));

    // R9 no response to a write
    a_r9_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_we_i) |=> !rsp_valid_o);

    // R6 busy blocks acceptance
    a_r6_busy_stall: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !req_ready_o);

    // R6 spacing between accesses to one bank, tracked by counters
    for (genvar b = 0; b < NB; b++) begin : g_gap
        int since_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                since_q <= LAT;
            else if (acc && in_rng && int'(bank_o) == b)
                since_q <= 0;
            else if (since_q < LAT)
                since_q <= since_q + 1;
        end
        a_r6_bank_gap: assert property (@(posedge clk) disable iff (!rst_n)
            (acc && in_rng && int'(bank_o) == b) |-> since_q >= LAT - 1);
    end
endmodule

bind imap_top imap_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_BITS(BANK_BITS),
    .ROW_BITS(ROW_BITS), .LAT(LAT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_addr_i  (req_addr_i),
    .req_we_i    (req_we_i),
    .rsp_valid_o (rsp_valid_o),
    .err_o       (err_o),
    .bank_o      (bank_o),
    .row_o       (row_o),
    .busy_o      (busy_o)
);

// File: tb/sim_imap_top.sv
`timescale 1ns/1ps
module sim_imap_top;
    localparam int NB  = 3;
    localparam int WB  = 8;
    localparam int LAT = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_i = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        req_ready_o;
    logic [7:0]  req_addr_i = '0;
    logic        req_we_i = 1'b0;
    logic [31:0] req_wdata_i = '0;
    logic        rsp_valid_o;
    logic [31:0] rsp_rdata_o;
    logic        err_o;
    logic [1:0]  bank_o;
    logic [2:0]  row_o;
    logic        busy_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    imap_top u0 (.*);

    // address, residue bank/row, sequential bank/row
    localparam int NV = 9;
    localparam int T_ADDR [NV] = '{0, 8, 9, 23, 17, 5, 12, 22, 16};
    localparam int T_MB   [NV] = '{0, 2, 0,  2,  2, 2,  0,  1,  1};
    localparam int T_MR   [NV] = '{0, 0, 1,  7,  1, 5,  4,  6,  0};
    localparam int T_SB   [NV] = '{0, 2, 0,  2,  2, 2,  0,  1,  1};
    localparam int T_SR   [NV] = '{0, 2, 3,  7,  5, 1,  4,  7,  5};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pattern(input int a, input logic m);
        return 32'hA500_0000 ^ (32'(a) * 32'h0001_1111) ^ {31'b0, m};
    endfunction

    // called at a negedge; returns at the negedge after the accept edge
    task automatic xfer(input logic we, input int addr, input logic [31:0] data);
        req_valid_i = 1'b1;
        req_we_i    = we;
        req_addr_i  = addr[7:0];
        req_wdata_i = data;
        #1;
        while (!req_ready_o) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        req_valid_i = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit seen [NB*WB];
        int stall;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset state
        check("R8 rsp_valid", {31'b0, rsp_valid_o}, 32'd0);
        check("R8 err", {31'b0, err_o}, 32'd0);
        req_addr_i = 8'd4;
        req_valid_i = 1'b1;
        #1;
        check("R8 ready", {31'b0, req_ready_o}, 32'd1);
        check("R8 busy", {31'b0, busy_o}, 32'd0);
        req_valid_i = 1'b0;

        // table walk: mapping in both modes
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            req_addr_i = T_ADDR[i][7:0];
            mode_i = 1'b0;
            #1;
            check("R1 residue bank", 32'(bank_o), 32'(T_MB[i]));
            check("R2 residue row", 32'(row_o), 32'(T_MR[i]));
            mode_i = 1'b1;
            #1;
            check("R1 sequential bank", 32'(bank_o), 32'(T_SB[i]));
            check("R4 sequential row", 32'(row_o), 32'(T_SR[i]));
        end

        // R3 uniqueness over the full range
        mode_i = 1'b0;
        for (int a = 0; a < NB*WB; a++) begin
            req_addr_i = a[7:0];
            #1;
            check("R3 distinct cell", {31'b0, seen[int'(bank_o)*WB + int'(row_o)]}, 32'd0);
            seen[int'(bank_o)*WB + int'(row_o)] = 1'b1;
        end
        @(negedge clk);

        // R5/R9 write every address, then read back
        for (int a = 0; a < NB*WB; a++) begin
            xfer(1'b1, a, pattern(a, 1'b0));
            check("R9 no write rsp", {31'b0, rsp_valid_o}, 32'd0);
        end
        for (int a = 0; a < NB*WB; a++) begin
            xfer(1'b0, a, 32'h0);
            check("R5 rsp valid", {31'b0, rsp_valid_o}, 32'd1);
            check("R5 rdata", rsp_rdata_o, pattern(a, 1'b0));
            @(negedge clk);
            check("R5 single pulse", {31'b0, rsp_valid_o}, 32'd0);
        end

        // R6 stall on a busy bank, other bank free
        idle(LAT);
        xfer(1'b1, 0, pattern(0, 1'b0));
        req_addr_i = 8'd1;
        #1;
        check("R6 other bank ready", {31'b0, req_ready_o}, 32'd1);
        check("R6 other bank not busy", {31'b0, busy_o}, 32'd0);
        req_addr_i = 8'd3;
        #1;
        check("R6 busy flag", {31'b0, busy_o}, 32'd1);
        stall = 0;
        while (!req_ready_o && stall < 50) begin
            stall++;
            @(negedge clk);
            #1;
        end
        check("R6 stall cycles", 32'(stall), 32'(LAT - 1));
        @(negedge clk);

        // R7 out of range: no bank written or occupied
        idle(LAT);
        xfer(1'b1, 24, 32'hDEAD_BEEF);
        check("R7 err pulse", {31'b0, err_o}, 32'd1);
        check("R7 no rsp", {31'b0, rsp_valid_o}, 32'd0);
        req_addr_i = 8'd0;
        #1;
        check("R7 bank left free", {31'b0, req_ready_o}, 32'd1);
        @(negedge clk);
        check("R7 err drops", {31'b0, err_o}, 32'd0);
        xfer(1'b0, 0, 32'h0);
        check("R7 cell untouched", rsp_rdata_o, pattern(0, 1'b0));
        xfer(1'b0, 255, 32'h0);
        check("R7 top address err", {31'b0, err_o}, 32'd1);

        // R4 sequential layout round trip
        mode_i = 1'b1;
        idle(LAT);
        for (int a = 0; a < NB*WB; a++)
            xfer(1'b1, a, pattern(a, 1'b1));
        for (int a = NB*WB - 1; a >= 0; a--) begin
            xfer(1'b0, a, 32'h0);
            check("R4 sequential rdata", rsp_rdata_o, pattern(a, 1'b1));
        end

        idle(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule